// File: doc/BRIEF.md
# Mailbox Message Framer and Validator

This block connects a host command port to a pair of byte-wide mailbox queues that link to an embedded controller. A send command carries a module ID, an opcode and a 16-bit payload length. The block writes a four-byte header to the outbound queue and then forwards the payload bytes supplied by the host. A receive command carries the header the host expects. The block pulls a four-byte header from the inbound queue and compares it field by field. When every field matches, the block streams the payload back to the host. When any field differs, the block discards exactly the number of payload bytes the header announced, so that the next message starts on a header boundary, and it reports a mismatch.

All payload traffic uses valid/ready streams. On `tx_*` the block is the sink: it raises `tx_ready` only during the payload phase and only while the outbound queue has room. On `rx_*` the block is the source: `rx_valid` follows the inbound queue's not-empty flag during the payload phase and never depends on `rx_ready`. A byte moves in a cycle where both valid and ready are high. Both mailbox queues behave as first-word-fall-through FIFOs. The head byte is on `mb_rd_data` whenever `mb_empty` is low, and a high `mb_rd_en` pops it at the clock edge. A byte is pushed at the edge where `mb_wr_en` is high.

Each transaction ends with a single-cycle `done` pulse. `err_code` is valid in the same cycle. A wait on a mailbox flag that lasts `TMO_CYCLES` consecutive cycles without a transfer aborts the transaction.

Top module: `mbx_msg_engine`

## Requirements
- R1: Only one transaction runs at a time. `cmd_ready` is low from the cycle after acceptance until `done`. It is high in the `done` cycle, and the block never asserts `mb_wr_en` and `mb_rd_en` together.
- R2: A send writes its header in a fixed order: opcode, module ID, length bits 15:8, length bits 7:0.
- R3: After the header, a send writes exactly the requested number of payload bytes, in host order. The total is 4 + length pushes.
- R4: A zero-length send writes the four header bytes only and then finishes with no error.
- R5: A push happens only while `mb_full` is low. A full queue or a gap in `tx_valid` stalls the send without losing or repeating any byte.
- R6: A pop happens only while `mb_empty` is low. An empty queue or a low `rx_ready` stalls the payload stream without losing or repeating any byte.
- R7: A receive whose opcode, module ID and 16-bit big-endian length (header bytes 2 and 3) all match the expected values streams all length bytes in order on `rx_*`. It then ends with error code 0.
- R8: If the opcode, the module ID or the length differs, the block pops exactly the advertised number of payload bytes and presents none of them on `rx_*`. It then ends with error code 1.
- R9: If the block waits `TMO_CYCLES` consecutive cycles for a flag with no transfer, it abandons the transaction. `done` rises one cycle later with error code 2. Each completed byte restarts the wait count.
- R10: `done` is high for exactly one cycle per accepted command. Its error codes are 0 for success, 1 for a header mismatch and 2 for a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High when the block can accept a command |
| cmd_dir | input | 1 | 0 = send a message, 1 = receive and validate |
| cmd_module | input | 8 | Module ID to send or expect |
| cmd_opcode | input | 8 | Opcode to send or expect |
| cmd_len | input | 16 | Payload length to send or expect |
| tx_valid | input | 1 | Host payload byte valid |
| tx_ready | output | 1 | Block takes the host payload byte |
| tx_data | input | 8 | Host payload byte |
| rx_valid | output | 1 | Received payload byte valid |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Received payload byte |
| mb_full | input | 1 | Outbound queue full |
| mb_wr_en | output | 1 | Push to the outbound queue |
| mb_wr_data | output | 8 | Byte pushed to the outbound queue |
| mb_empty | input | 1 | Inbound queue empty |
| mb_rd_en | output | 1 | Pop from the inbound queue |
| mb_rd_data | input | 8 | Head byte of the inbound queue |
| done | output | 1 | Transaction finished (one cycle) |
| err_code | output | 2 | Result code, valid while `done` is high |

## Verification
The embedded properties check several things on every cycle. `done` lasts exactly one cycle, and the block is idle again when it fires. The two mailbox directions are never active together. The wait counter never passes its limit. A successful send or receive has moved exactly four header bytes plus the length. Other behaviour appears only in the bench's scenarios. These include the byte order of the header and payload, payload integrity under stalls on both sides, the exact amount discarded after each kind of header mismatch, and the exact cycle at which a timeout ends a transaction. They also include the proof that byte-by-byte restarts keep a long but steady message from timing out.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_BYTE_W = 8;
  localparam int MBX_LEN_W  = 16;
  localparam int MBX_HDR_N  = 4;
  localparam int MBX_IDX_W  = $clog2(MBX_HDR_N);

  typedef enum logic [1:0] {
    MBX_OK      = 2'd0,
    MBX_BAD_HDR = 2'd1,
    MBX_TIMEOUT = 2'd2
  } mbx_err_e;

  // Header position -> byte: opcode, module, length high, length low
  function automatic logic [MBX_BYTE_W-1:0] mbx_hdr_byte(
      input logic [MBX_IDX_W-1:0]  idx,
      input logic [MBX_BYTE_W-1:0] op,
      input logic [MBX_BYTE_W-1:0] modid,
      input logic [MBX_LEN_W-1:0]  len);
    case (idx)
      2'd0:    return op;
      2'd1:    return modid;
      2'd2:    return len[MBX_LEN_W-1:MBX_BYTE_W];
      default: return len[MBX_BYTE_W-1:0];
    endcase
  endfunction
endpackage

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic waiting,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expired = waiting && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (waiting)    cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (cnt < CW'(LIMIT))); // R9
endmodule

// File: rtl/mbx_tx_framer.sv
module mbx_tx_framer
  import mbx_pkg::*;
#(
  parameter int TMO_CYCLES = 5000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [MBX_BYTE_W-1:0] op,
  input  logic [MBX_BYTE_W-1:0] modid,
  input  logic [MBX_LEN_W-1:0]  len,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [MBX_BYTE_W-1:0] tx_data,
  input  logic                  mb_full,
  output logic                  mb_wr_en,
  output logic [MBX_BYTE_W-1:0] mb_wr_data,
  output logic                  busy,
  output logic                  done,
  output mbx_err_e              err
);
  typedef enum logic [1:0] {TX_IDLE, TX_HDR, TX_PAY} tx_state_e;

  tx_state_e              state;
  logic [MBX_IDX_W-1:0]   idx;
  logic [MBX_LEN_W-1:0]   remain;
  logic [MBX_BYTE_W-1:0]  op_q, mod_q;
  logic [MBX_LEN_W-1:0]   len_q;
  logic                   expired;

  always_comb begin
    tx_ready   = 1'b0;
    mb_wr_en   = 1'b0;
    mb_wr_data = mbx_hdr_byte(idx, op_q, mod_q, len_q);
    case (state)
      TX_HDR: mb_wr_en = !mb_full;
      TX_PAY: begin
        tx_ready   = !mb_full;
        mb_wr_en   = tx_valid && !mb_full;
        mb_wr_data = tx_data;
      end
      default: ;
    endcase
  end

  assign busy = (state != TX_IDLE);

  mbx_wait_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start || mb_wr_en),
    .waiting (busy && mb_full),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      idx    <= '0;
      remain <= '0;
      op_q   <= '0;
      mod_q  <= '0;
      len_q  <= '0;
      done   <= 1'b0;
      err    <= MBX_OK;
    end else begin
      done <= 1'b0;
      case (state)
        TX_IDLE: if (start) begin
          op_q  <= op;
          mod_q <= modid;
          len_q <= len;
          idx   <= '0;
          state <= TX_HDR;
        end
        TX_HDR: begin
          if (expired) begin
            state <= TX_IDLE; done <= 1'b1; err <= MBX_TIMEOUT;
          end else if (mb_wr_en) begin
            idx <= idx + 1'b1;
            if (idx == MBX_IDX_W'(MBX_HDR_N - 1)) begin
              if (len_q == '0) begin
                state <= TX_IDLE; done <= 1'b1; err <= MBX_OK;
              end else begin
                state  <= TX_PAY;
                remain <= len_q;
              end
            end
          end
        end
        TX_PAY: begin
          if (expired) begin
            state <= TX_IDLE; done <= 1'b1; err <= MBX_TIMEOUT;
          end else if (mb_wr_en) begin
            remain <= remain - 1'b1;
            if (remain == MBX_LEN_W'(1)) begin
              state <= TX_IDLE; done <= 1'b1; err <= MBX_OK;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  AST_TX_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_PAY && mb_full) |=> $stable(remain)); // R5
endmodule

// File: rtl/mbx_rx_validator.sv
module mbx_rx_validator
  import mbx_pkg::*;
#(
  parameter int TMO_CYCLES = 5000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [MBX_BYTE_W-1:0] exp_op,
  input  logic [MBX_BYTE_W-1:0] exp_mod,
  input  logic [MBX_LEN_W-1:0]  exp_len,
  input  logic                  mb_empty,
  output logic                  mb_rd_en,
  input  logic [MBX_BYTE_W-1:0] mb_rd_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [MBX_BYTE_W-1:0] rx_data,
  output logic                  busy,
  output logic                  done,
  output mbx_err_e              err
);
  typedef enum logic [1:0] {RX_IDLE, RX_HDR, RX_PAY, RX_DRAIN} rx_state_e;

  rx_state_e              state;
  logic [MBX_IDX_W-1:0]   idx;
  logic [MBX_LEN_W-1:0]   remain;
  logic [MBX_BYTE_W-1:0]  op_q, mod_q, hb0, hb1, hb2;
  logic [MBX_LEN_W-1:0]   len_q;
  logic [MBX_LEN_W-1:0]   adv_len;
  logic                   hdr_match;
  logic                   expired;

  assign adv_len   = {hb2, mb_rd_data};
  assign hdr_match = (hb0 == op_q) && (hb1 == mod_q) && (adv_len == len_q);
  assign rx_data   = mb_rd_data;
  assign busy      = (state != RX_IDLE);

  always_comb begin
    rx_valid = 1'b0;
    mb_rd_en = 1'b0;
    case (state)
      RX_HDR, RX_DRAIN: mb_rd_en = !mb_empty;
      RX_PAY: begin
        rx_valid = !mb_empty;
        mb_rd_en = rx_ready && !mb_empty;
      end
      default: ;
    endcase
  end

  mbx_wait_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start || mb_rd_en),
    .waiting (busy && mb_empty),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      idx    <= '0;
      remain <= '0;
      op_q   <= '0;
      mod_q  <= '0;
      len_q  <= '0;
      hb0    <= '0;
      hb1    <= '0;
      hb2    <= '0;
      done   <= 1'b0;
      err    <= MBX_OK;
    end else begin
      done <= 1'b0;
      case (state)
        RX_IDLE: if (start) begin
          op_q  <= exp_op;
          mod_q <= exp_mod;
          len_q <= exp_len;
          idx   <= '0;
          state <= RX_HDR;
        end
        RX_HDR: begin
          if (expired) begin
            state <= RX_IDLE; done <= 1'b1; err <= MBX_TIMEOUT;
          end else if (mb_rd_en) begin
            idx <= idx + 1'b1;
            case (idx)
              2'd0: hb0 <= mb_rd_data;
              2'd1: hb1 <= mb_rd_data;
              2'd2: hb2 <= mb_rd_data;
              default: begin
                if (hdr_match) begin
                  if (len_q == '0) begin
                    state <= RX_IDLE; done <= 1'b1; err <= MBX_OK;
                  end else begin
                    state <= RX_PAY; remain <= len_q;
                  end
                end else if (adv_len == '0) begin
                  state <= RX_IDLE; done <= 1'b1; err <= MBX_BAD_HDR;
                end else begin
                  state <= RX_DRAIN; remain <= adv_len;
                end
              end
            endcase
          end
        end
        RX_PAY, RX_DRAIN: begin
          if (expired) begin
            state <= RX_IDLE; done <= 1'b1; err <= MBX_TIMEOUT;
          end else if (mb_rd_en) begin
            remain <= remain - 1'b1;
            if (remain == MBX_LEN_W'(1)) begin
              state <= RX_IDLE;
              done  <= 1'b1;
              err   <= (state == RX_PAY) ? MBX_OK : MBX_BAD_HDR;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_RX_DRAIN_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DRAIN && mb_rd_en) |=> !rx_valid || (state != RX_DRAIN)); // R8
endmodule

// File: rtl/mbx_msg_engine.sv
module mbx_msg_engine
  import mbx_pkg::*;
#(
  parameter int TMO_CYCLES = 5000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_dir,
  input  logic [7:0]  cmd_module,
  input  logic [7:0]  cmd_opcode,
  input  logic [15:0] cmd_len,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [7:0]  tx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [7:0]  rx_data,
  input  logic        mb_full,
  output logic        mb_wr_en,
  output logic [7:0]  mb_wr_data,
  input  logic        mb_empty,
  output logic        mb_rd_en,
  input  logic [7:0]  mb_rd_data,
  output logic        done,
  output logic [1:0]  err_code
);
  logic     accept, tx_busy, rx_busy, tx_done, rx_done;
  mbx_err_e tx_err, rx_err;

  assign cmd_ready = !(tx_busy || rx_busy);
  assign accept    = cmd_valid && cmd_ready;

  mbx_tx_framer #(.TMO_CYCLES(TMO_CYCLES)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && !cmd_dir),
    .op         (cmd_opcode),
    .modid      (cmd_module),
    .len        (cmd_len),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .mb_full    (mb_full),
    .mb_wr_en   (mb_wr_en),
    .mb_wr_data (mb_wr_data),
    .busy       (tx_busy),
    .done       (tx_done),
    .err        (tx_err)
  );

  mbx_rx_validator #(.TMO_CYCLES(TMO_CYCLES)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && cmd_dir),
    .exp_op     (cmd_opcode),
    .exp_mod    (cmd_module),
    .exp_len    (cmd_len),
    .mb_empty   (mb_empty),
    .mb_rd_en   (mb_rd_en),
    .mb_rd_data (mb_rd_data),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_data    (rx_data),
    .busy       (rx_busy),
    .done       (rx_done),
    .err        (rx_err)
  );

  assign done     = tx_done || rx_done;
  assign err_code = tx_done ? tx_err : rx_err;

  // Per-transaction byte tally, kept for the checks below
  logic [MBX_LEN_W:0]   xfer_cnt;
  logic [MBX_LEN_W-1:0] len_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_cnt <= '0;
      len_seen <= '0;
    end else if (accept) begin
      xfer_cnt <= '0;
      len_seen <= cmd_len;
    end else if (mb_wr_en || mb_rd_en) begin
      xfer_cnt <= xfer_cnt + 1'b1;
    end
  end

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mb_wr_en && mb_rd_en)); // R1
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_TX_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_err == MBX_OK) |-> (xfer_cnt == {1'b0, len_seen} + 17'd4)); // R3
  AST_RX_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_err == MBX_OK) |-> (xfer_cnt == {1'b0, len_seen} + 17'd4)); // R7
endmodule

// File: tb/sim_mbx_msg_engine.sv
module sim_mbx_msg_engine;
  localparam int TMO = 16;
  localparam int GAP = TMO - 3;
  localparam int NV  = 11;
  // {dir, stall, 6'b0, op, mod, len, in_op, in_mod, in_len, 6'b0, err}
  localparam logic [63:0] VEC [NV] = '{
    {1'b0,1'b0,6'd0, 8'h11,8'h01,8'd6, 8'h00,8'h00,8'd0, 6'd0,2'd0},
    {1'b0,1'b0,6'd0, 8'h22,8'h02,8'd0, 8'h00,8'h00,8'd0, 6'd0,2'd0},
    {1'b0,1'b1,6'd0, 8'h33,8'h01,8'd5, 8'h00,8'h00,8'd0, 6'd0,2'd0},
    {1'b1,1'b0,6'd0, 8'h44,8'h01,8'd3, 8'h44,8'h01,8'd3, 6'd0,2'd0},
    {1'b1,1'b0,6'd0, 8'h44,8'h01,8'd3, 8'h45,8'h01,8'd3, 6'd0,2'd1},
    {1'b1,1'b0,6'd0, 8'h44,8'h01,8'd3, 8'h44,8'h07,8'd4, 6'd0,2'd1},
    {1'b1,1'b0,6'd0, 8'h44,8'h01,8'd2, 8'h44,8'h01,8'd5, 6'd0,2'd1},
    {1'b1,1'b0,6'd0, 8'h50,8'h03,8'd0, 8'h50,8'h03,8'd0, 6'd0,2'd0},
    {1'b1,1'b0,6'd0, 8'h51,8'h03,8'd2, 8'h52,8'h03,8'd0, 6'd0,2'd1},
    {1'b1,1'b1,6'd0, 8'h60,8'h02,8'd7, 8'h60,8'h02,8'd7, 6'd0,2'd0},
    {1'b0,1'b0,6'd0, 8'h77,8'h09,8'd9, 8'h00,8'h00,8'd0, 6'd0,2'd0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, cmd_dir;
  logic [7:0]  cmd_module, cmd_opcode;
  logic [15:0] cmd_len;
  logic        tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;
  logic        mb_full, mb_wr_en, mb_empty, mb_rd_en;
  logic [7:0]  mb_wr_data, mb_rd_data;
  logic        done;
  logic [1:0]  err_code;

  int checks = 0;
  int fails  = 0;

  logic [7:0] inq  [1024];
  logic [7:0] outq [1024];
  logic [7:0] rxq  [1024];
  int in_head = 0, in_tail = 0, out_n = 0, rx_n = 0, tx_cnt = 0, gap_ctr = 0;
  int tx_base = 0, tx_len = 0;
  logic [7:0] tx_op = 8'h00;
  logic [2:0] stall_cnt = 3'd0;
  logic stall_on = 1'b0, full_force = 1'b0, gap_on = 1'b0, tx_on = 1'b0;

  function automatic logic [7:0] txpay(input logic [7:0] op, input int i);
    return op + 8'(i * 5);
  endfunction
  function automatic logic [7:0] rxpay(input logic [7:0] op, input int i);
    return op ^ 8'(i * 3 + 1);
  endfunction

  assign mb_full    = full_force || (stall_on && stall_cnt[0]);
  assign mb_empty   = (in_head == in_tail) || (stall_on && stall_cnt[1]) || (gap_ctr != 0);
  assign mb_rd_data = inq[in_head % 1024];
  assign tx_valid   = tx_on && ((tx_cnt - tx_base) < tx_len) && !(stall_on && stall_cnt[2]);
  assign tx_data    = txpay(tx_op, tx_cnt - tx_base);
  assign rx_ready   = !(stall_on && stall_cnt[2]);

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 3'd1;
    if (mb_rd_en) in_head <= in_head + 1;
    if (mb_wr_en) begin outq[out_n % 1024] <= mb_wr_data; out_n <= out_n + 1; end
    if (rx_valid && rx_ready) begin rxq[rx_n % 1024] <= rx_data; rx_n <= rx_n + 1; end
    if (tx_valid && tx_ready) tx_cnt <= tx_cnt + 1;
    if (gap_on && mb_rd_en) gap_ctr <= GAP;
    else if (gap_ctr > 0)   gap_ctr <= gap_ctr - 1;
  end

  mbx_msg_engine #(.TMO_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dir(cmd_dir), .cmd_module(cmd_module), .cmd_opcode(cmd_opcode),
    .cmd_len(cmd_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .mb_full(mb_full), .mb_wr_en(mb_wr_en),
    .mb_wr_data(mb_wr_data), .mb_empty(mb_empty), .mb_rd_en(mb_rd_en),
    .mb_rd_data(mb_rd_data), .done(done), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_in(input logic [7:0] b);
    inq[in_tail % 1024] = b;
    in_tail = in_tail + 1;
  endtask

  task automatic load_msg(input logic [7:0] op, input logic [7:0] md, input int len);
    push_in(op); push_in(md); push_in(8'(len >> 8)); push_in(8'(len));
    for (int i = 0; i < len; i++) push_in(rxpay(op, i));
  endtask

  task automatic issue(input logic dir, input logic [7:0] op, input logic [7:0] md, input int len);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_dir = dir; cmd_opcode = op; cmd_module = md; cmd_len = 16'(len);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  // Waits for done; also records whether cmd_ready was ever high while busy
  task automatic wait_done(output int n, output logic [1:0] e, output bit ready_seen);
    n = 0; e = 2'd3; ready_seen = 1'b0;
    forever begin
      @(negedge clk);
      n++;
      if (done) begin e = err_code; break; end
      if (cmd_ready) ready_seen = 1'b1;
      if (n > 5000) begin chk(1'b0, "R10 watchdog", n, 0); break; end
    end
    @(negedge clk);
    chk(!done, "R10 done width", done, 0);
  endtask

  initial begin
    int n;
    logic [1:0] e;
    bit rs;
    cmd_valid = 1'b0; cmd_dir = 1'b0; cmd_opcode = '0; cmd_module = '0; cmd_len = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    chk({done, mb_wr_en, mb_rd_en, tx_ready, rx_valid} == 5'b0, "R10 reset outputs",
        {done, mb_wr_en, mb_rd_en, tx_ready, rx_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      logic dir, stl;
      logic [7:0] op, md, iop, imd;
      int len, ilen, ob, rb, bad;
      logic [1:0] xe;
      dir = VEC[v][63]; stl = VEC[v][62];
      op = VEC[v][55:48]; md = VEC[v][47:40]; len = int'(VEC[v][39:32]);
      iop = VEC[v][31:24]; imd = VEC[v][23:16]; ilen = int'(VEC[v][15:8]);
      xe = VEC[v][1:0];
      ob = out_n; rb = rx_n;
      stall_on = stl;
      if (dir) load_msg(iop, imd, ilen);
      else begin tx_op = op; tx_base = tx_cnt; tx_len = len; tx_on = 1'b1; end
      issue(dir, op, md, len);
      wait_done(n, e, rs);
      tx_on = 1'b0; stall_on = 1'b0;
      chk(e == xe, "R10 result code", e, xe);
      chk(!rs, "R1 busy blocks commands", rs, 0);
      if (!dir) begin
        bad = 0;
        if (outq[ob % 1024] != op || outq[(ob+1) % 1024] != md ||
            outq[(ob+2) % 1024] != 8'(len >> 8) || outq[(ob+3) % 1024] != 8'(len)) bad = 1;
        chk(bad == 0, "R2 header order", bad, 0);
        chk(out_n - ob == 4 + len, len == 0 ? "R4 header only" : "R3 push count", out_n - ob, 4 + len);
        bad = 0;
        for (int i = 0; i < len; i++)
          if (outq[(ob + 4 + i) % 1024] != txpay(op, i)) bad++;
        chk(bad == 0, stl ? "R5 payload under stall" : "R3 payload order", bad, 0);
      end else begin
        chk(in_head == in_tail, xe == 2'd1 ? "R8 drain exact" : "R7 consumed", in_tail - in_head, 0);
        if (xe == 2'd1) chk(rx_n == rb, "R8 nothing forwarded", rx_n - rb, 0);
        else begin
          bad = 0;
          for (int i = 0; i < len; i++)
            if (rxq[(rb + i) % 1024] != rxpay(iop, i)) bad++;
          chk(rx_n - rb == len && bad == 0, stl ? "R6 payload under stall" : "R7 payload",
              rx_n - rb + bad * 1000, len);
        end
      end
    end

    // Send with the outbound queue stuck full
    full_force = 1'b1; tx_op = 8'h80; tx_base = tx_cnt; tx_len = 2; tx_on = 1'b1;
    issue(1'b0, 8'h80, 8'h01, 2);
    wait_done(n, e, rs);
    tx_on = 1'b0; full_force = 1'b0;
    chk(e == 2'd2, "R9 send timeout code", e, 2);
    chk(n == TMO + 1, "R9 send timeout cycle", n, TMO + 1);

    // Receive with nothing arriving
    issue(1'b1, 8'h81, 8'h01, 1);
    wait_done(n, e, rs);
    chk(e == 2'd2, "R9 receive timeout code", e, 2);
    chk(n == TMO + 1, "R9 receive timeout cycle", n, TMO + 1);

    // Slow but steady arrival: each byte restarts the wait count
    gap_on = 1'b1;
    begin
      int rb;
      int bad;
      rb = rx_n;
      load_msg(8'h66, 8'h02, 6);
      issue(1'b1, 8'h66, 8'h02, 6);
      wait_done(n, e, rs);
      gap_on = 1'b0;
      chk(e == 2'd0, "R9 restart per byte", e, 0);
      bad = 0;
      for (int i = 0; i < 6; i++) if (rxq[(rb + i) % 1024] != rxpay(8'h66, i)) bad++;
      chk(rx_n - rb == 6 && bad == 0, "R9 slow payload", rx_n - rb + bad * 1000, 6);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 global watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule